// File: doc/BRIEF.md
# Reference Tick Divider

This block turns an external, asynchronous reference clock into a slow, single-cycle enable pulse in the system clock domain, for use as the time base of a frequency-measurement engine. The external input is synchronised and each rising edge becomes one internal count enable. The edges then pass through three chained stages: an optional fixed divide-by-32 for fast sources, a power-of-two prescaler, and a programmable divide-by-(N+1) stage.

A 2-bit source field picks the path: reference disabled, a direct slow source (crystal or low-frequency oscillator), or a fast source that is first divided by 32. The configuration arrives as register fields. Any change to them restarts all counting from zero. Two further fields, a 5-bit slope-correction value and an 8-bit offset value, are only registered and passed on unchanged for use elsewhere.

Top module: `ref_tick_gen`

## Requirements
- R1: The source field src_sel_i encodes 2'b00 = off, 2'b01 = slow crystal used directly, 2'b10 = fast source divided by 32, 2'b11 = slow source used directly.
- R2: The prescaler field pre_sel_i = n divides the edge rate by 2^n, from 1 (n=0) to 128 (n=7).
- R3: The divider field div_n_i = N divides by N+1, from 1 (N=0) to 256 (N=255).
- R4: Rising edges of the asynchronous ext_clk_i are synchronised and counted; tick_o is high for exactly one system clock cycle per output pulse.
- R5: With total ratio T = P*2^n*(N+1), where P is 32 for source 2'b10 and 1 otherwise, the k-th pulse of tick_o follows the (k*T)-th rising edge counted from the last restart. No pulse occurs before that edge.
- R6: Any change of src_sel_i, pre_sel_i or div_n_i clears all counters, and tick_o is low in the following cycle.
- R7: While src_sel_i is 2'b00 or pwr_on_i is low, tick_o stays low and all counters are held at zero.
- R8: slope_o and offset_o equal slope_i and offset_i as sampled at the previous clock edge.
- R9: After reset, tick_o, slope_o and offset_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_clk_i | input | 1 | Asynchronous external reference clock |
| pwr_on_i | input | 1 | Radio power enable; low holds the divider idle |
| src_sel_i | input | 2 | Source select |
| pre_sel_i | input | 3 | Power-of-two prescaler exponent |
| div_n_i | input | 8 | Divider value N (ratio N+1) |
| slope_i | input | 5 | Slope-correction value, passed through |
| offset_i | input | 8 | Offset value, passed through |
| tick_o | output | 1 | Single-cycle reference tick |
| slope_o | output | 5 | Registered slope-correction value |
| offset_o | output | 8 | Registered offset value |

## Verification
The bench targets the edge counts just below and at a multiple of the total ratio. An off-by-one in any stage would give a tick one edge early or never. The extremes N=0, N=255 and n=7 check counter widths and wrap limits. The fast-source predivide is checked separately, because a design that ignored it would tick 32 times too often. The bench also leaves a partial count, changes the configuration or drops power, and then checks that the next tick needs a full new ratio of edges. A design that kept stale counts would tick early.

// File: rtl/ref_tick_pkg.sv
package ref_tick_pkg;
  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_XTAL = 2'b01,
    SRC_HF   = 2'b10,
    SRC_LF   = 2'b11
  } src_sel_e;

  localparam int unsigned PRE_W    = 3;
  localparam int unsigned DIV_W    = 8;
  localparam int unsigned HF_DIV   = 32;
  localparam int unsigned HF_W     = $clog2(HF_DIV);
  localparam int unsigned PSC_W    = (1 << PRE_W) - 1;
  localparam int unsigned SLOPE_W  = 5;
  localparam int unsigned OFFSET_W = 8;
endpackage

// File: rtl/ext_edge_sync.sv
module ext_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= async_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] limit_i,
  output logic         pulse_o
);
  logic [W-1:0] cnt_q;

  assign pulse_o = en_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (pulse_o) cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ref_tick_gen.sv
module ref_tick_gen
  import ref_tick_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ext_clk_i,
  input  logic                pwr_on_i,
  input  logic [1:0]          src_sel_i,
  input  logic [PRE_W-1:0]    pre_sel_i,
  input  logic [DIV_W-1:0]    div_n_i,
  input  logic [SLOPE_W-1:0]  slope_i,
  input  logic [OFFSET_W-1:0] offset_i,
  output logic                tick_o,
  output logic [SLOPE_W-1:0]  slope_o,
  output logic [OFFSET_W-1:0] offset_o
);
  localparam int unsigned CFG_W = 2 + PRE_W + DIV_W;

  logic             rise;
  logic             clr;
  logic             cfg_chg;
  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic             hf_sel;
  logic             hf_pulse, psc_in, psc_pulse, div_pulse;
  logic [PSC_W-1:0] psc_limit;
  logic             tick_q;
  logic [SLOPE_W-1:0]  slope_q;
  logic [OFFSET_W-1:0] offset_q;

  ext_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ext_clk_i),
    .rise_o (rise)
  );

  assign cfg_now = {src_sel_i, pre_sel_i, div_n_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_now;
  end

  assign cfg_chg = (cfg_now != cfg_q);
  assign clr     = cfg_chg || !pwr_on_i || (src_sel_e'(src_sel_i) == SRC_OFF);
  assign hf_sel  = (src_sel_e'(src_sel_i) == SRC_HF);

  cnt_stage #(.W(HF_W)) i_hf_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .en_i   (rise && hf_sel),
    .limit_i(HF_W'(HF_DIV - 1)),
    .pulse_o(hf_pulse)
  );

  assign psc_in    = hf_sel ? hf_pulse : rise;
  assign psc_limit = PSC_W'((1 << pre_sel_i) - 1);

  cnt_stage #(.W(PSC_W)) i_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .en_i   (psc_in),
    .limit_i(psc_limit),
    .pulse_o(psc_pulse)
  );

  cnt_stage #(.W(DIV_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .en_i   (psc_pulse),
    .limit_i(div_n_i),
    .pulse_o(div_pulse)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q   <= 1'b0;
      slope_q  <= '0;
      offset_q <= '0;
    end else begin
      tick_q   <= div_pulse && !clr;
      slope_q  <= slope_i;
      offset_q <= offset_i;
    end
  end

  assign tick_o   = tick_q;
  assign slope_o  = slope_q;
  assign offset_o = offset_q;
endmodule

// File: rtl/ref_tick_chk.sv
module ref_tick_chk
  import ref_tick_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                pwr_on_i,
  input logic [1:0]          src_sel_i,
  input logic [PRE_W-1:0]    pre_sel_i,
  input logic [DIV_W-1:0]    div_n_i,
  input logic [SLOPE_W-1:0]  slope_i,
  input logic [OFFSET_W-1:0] offset_i,
  input logic                tick_o,
  input logic [SLOPE_W-1:0]  slope_o,
  input logic [OFFSET_W-1:0] offset_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assert_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  assert_idle_when_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == 2'b00 || !pwr_on_i) |=> !tick_o);

  assert_restart_on_cfg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !($stable(src_sel_i) && $stable(pre_sel_i) && $stable(div_n_i))) |=> !tick_o);

  assert_passthrough_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (slope_o == $past(slope_i) && offset_o == $past(offset_i)));
endmodule

bind ref_tick_gen ref_tick_chk i_ref_tick_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pwr_on_i (pwr_on_i),
  .src_sel_i(src_sel_i),
  .pre_sel_i(pre_sel_i),
  .div_n_i  (div_n_i),
  .slope_i  (slope_i),
  .offset_i (offset_i),
  .tick_o   (tick_o),
  .slope_o  (slope_o),
  .offset_o (offset_o)
);

// File: tb/test_ref_tick_gen.sv
`timescale 1ns/1ps
module test_ref_tick_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext = 1'b0;
  logic       pwr = 1'b0;
  logic [1:0] src = 2'b00;
  logic [2:0] pre = 3'd0;
  logic [7:0] dn  = 8'd0;
  logic [4:0] slope = 5'd0;
  logic [7:0] offs  = 8'd0;
  logic       tick;
  logic [4:0] slope_q;
  logic [7:0] offs_q;

  int checks = 0;
  int fails  = 0;
  int ticks  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  ref_tick_gen i_ref_tick_gen (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext), .pwr_on_i(pwr),
    .src_sel_i(src), .pre_sel_i(pre), .div_n_i(dn),
    .slope_i(slope), .offset_i(offs),
    .tick_o(tick), .slope_o(slope_q), .offset_o(offs_q)
  );

  always @(negedge clk) if (tick) ticks++;

  function automatic int unsigned exp_total(logic [1:0] s, logic [2:0] p, logic [7:0] n);
    int unsigned pd = (s == 2'b10) ? 32 : 1;
    return pd * (1 << p) * (n + 1);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(int unsigned k);
    for (int unsigned i = 0; i < k; i++) begin
      @(negedge clk) ext = 1'b1;
      @(negedge clk);
      @(negedge clk) ext = 1'b0;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic set_cfg(logic [1:0] s, logic [2:0] p, logic [7:0] n);
    @(negedge clk);
    src = s; pre = p; dn = n;
    repeat (3) @(negedge clk);
  endtask

  // k-th tick only after exactly k*T edges (R5)
  task automatic run_case(string req, logic [1:0] s, logic [2:0] p, logic [7:0] n, int unsigned m);
    int unsigned t;
    set_cfg(s, p, n);
    t = exp_total(s, p, n);
    ticks = 0;
    edges(t * m - 1);
    check({req, " R5 before"}, ticks, m - 1);
    edges(1);
    check({req, " R5 at"}, ticks, m);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R9 tick", tick, 0);
    check("R9 slope", slope_q, 0);
    check("R9 offset", offs_q, 0);
    rst_n = 1'b1;
    pwr = 1'b1;

    // R8 pass-through
    @(negedge clk) slope = 5'h15; offs = 8'hA7;
    @(negedge clk);
    check("R8 slope", slope_q, 5'h15);
    check("R8 offset", offs_q, 8'hA7);

    // R7 src off: no ticks
    set_cfg(2'b00, 3'd0, 8'd0);
    ticks = 0; edges(10);
    check("R7 src off", ticks, 0);

    run_case("R3 R4 N=0 direct", 2'b11, 3'd0, 8'd0, 5);
    run_case("R1 xtal", 2'b01, 3'd1, 8'd2, 2);
    run_case("R3 N=255", 2'b11, 3'd0, 8'd255, 1);
    run_case("R2 n=7", 2'b11, 3'd7, 8'd0, 2);
    run_case("R1 hf /32", 2'b10, 3'd0, 8'd0, 3);
    run_case("R2 R3 mix", 2'b11, 3'd2, 8'd4, 2);

    // R6: partial count then config change restarts
    set_cfg(2'b11, 3'd0, 8'd9);
    ticks = 0; edges(9);
    set_cfg(2'b11, 3'd0, 8'd3);
    edges(3);
    check("R6 no stale tick", ticks, 0);
    edges(1);
    check("R6 fresh tick", ticks, 1);

    // R7: power off holds counters cleared
    set_cfg(2'b11, 3'd2, 8'd1);
    ticks = 0; edges(7);
    @(negedge clk) pwr = 1'b0;
    edges(5);
    check("R7 pwr off", ticks, 0);
    @(negedge clk) pwr = 1'b1;
    edges(7);
    check("R7 cleared", ticks, 0);
    edges(1);
    check("R7 resume", ticks, 1);

    // random mix
    for (int it = 0; it < 12; it++) begin
      logic [1:0] s;
      logic [2:0] p;
      logic [7:0] n;
      s = 2'(1 + ($urandom % 3));
      p = 3'($urandom % ((s == 2'b10) ? 3 : 5));
      n = 8'($urandom % ((s == 2'b10) ? 4 : 12));
      slope = 5'($urandom); offs = 8'($urandom);
      run_case("R1 R2 R3 random", s, p, n, 1 + ($urandom % 2));
      check("R8 random slope", slope_q, slope);
      check("R8 random offset", offs_q, offs);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule